// File: doc/BRIEF.md
# Shared-Ramp Parallel Code Latch Bank

This block digitises a whole bank of stored analog samples in one pass. A single ramp counter is shared by every cell; the analog ramp, its DAC and the per-cell comparators sit outside and reach the block only as one comparator bit per cell. A start request clears all previous results and runs the counter from 0 up to its terminal value. Each cell keeps the count seen on the first rising edge of its own comparator. Because the ramp leaves its start level together with the counter, the stored count is proportional to the cell voltage.

Comparator bits are asynchronous to the block clock. Each one passes through a two-flop synchronizer before edge detection. When the counter reaches its terminal value, any cell that never fired is given the full-scale code and an overflow flag. A one-cycle completion pulse follows. The results are then read back one cell at a time through an address and data port. Reads are refused while a conversion is running.

Top module: `wilk_latch_bank`

## Requirements
- R1: After reset, `busy`, `donePulse` and `rdValid` are 0. Every cell holds code 0 with its overflow flag clear.
- R2: A `startIn` pulse while idle raises `busy` on the next cycle and starts the shared counter at 0, stepping by one each cycle up to 4095. `busy` is therefore high for exactly 4096 cycles. A `startIn` while busy is ignored and does not shift the end of the conversion.
- R3: A cell whose comparator input goes from 0 to 1 in the cycle where the counter shows j stores code j+2. The two extra counts come from the two synchronizer stages and the edge detector.
- R4: Only the first synchronized rising edge after start is latched, and later toggles leave the code unchanged. A comparator that is already high at start is not counted until it has gone low and then high again.
- R5: At the end of a conversion, a cell that never fired holds code 4095 with overflow = 1. A cell whose edge falls in the terminal-count cycle stores 4095 with overflow = 0.
- R6: `donePulse` is high for exactly one cycle. That cycle immediately follows the terminal-count cycle, and `busy` is already 0 in it.
- R7: When idle, `rdEn` with `rdAddr` below the cell count gives `rdValid` = 1 on the next cycle, with that cell's code on `rdData` and its flag on `rdOvf`. In every other case `rdValid` is 0 on the next cycle.
- R8: A read requested while `busy` is high is refused: `rdValid` stays 0 on the next cycle.
- R9: A start that is accepted clears every cell's code and overflow flag before the new conversion begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start ramp and counter (accepted when idle) |
| cmpIn | input | NUM_CELLS | One asynchronous comparator bit per cell |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Cell index to read |
| rdData | output | CNT_W | Latched code of the addressed cell |
| rdOvf | output | 1 | Overflow flag of the addressed cell |
| rdValid | output | 1 | Read data valid (one cycle after an accepted request) |
| busy | output | 1 | Conversion in progress |
| donePulse | output | 1 | One-cycle completion pulse |

## Verification
The first conversion mixes several comparator patterns, and each one separates a different fault:
- A single early edge pins the two-cycle synchronizer latency.
- A high-low-high toggle shows whether only the first edge is kept.
- A comparator already high at start shows whether a level is wrongly taken for an edge.
- Edges placed one and two counts before the end separate the terminal-cycle capture from overflow marking.
- Never-firing cells check the full-scale fill.

A second conversion uses a spread of per-cell edge times and overlaps a read with the start request. Together these check that an accepted start clears the old results and that a read sees the pre-start state. Reads and restart requests issued during the ramp check refusal and the fixed 4096-cycle length.

// File: rtl/wilk_pkg.sv
package wilk_pkg;
  typedef struct packed {
    logic clearAll;   // wipe every cell at an accepted start
    logic captureEn;  // ramp running, edges may be latched
    logic finalize;   // terminal count reached this cycle
  } ctlStrobes_t;
endpackage

// File: rtl/wilk_ctrl.sv
module wilk_ctrl #(
  parameter int CNT_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startIn,
  output wilk_pkg::ctlStrobes_t    strobes,
  output logic [CNT_W-1:0]         count,
  output logic                     busy,
  output logic                     donePulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic {ST_IDLE, ST_RUN} ctlState_t;
  ctlState_t state;
  logic doneReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      count   <= '0;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: if (startIn) begin
          state <= ST_RUN;
          count <= '0;
        end
        ST_RUN: if (count == CNT_MAX) begin
          state   <= ST_IDLE;
          doneReg <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.clearAll  = (state == ST_IDLE) && startIn;
    strobes.captureEn = (state == ST_RUN);
    strobes.finalize  = (state == ST_RUN) && (count == CNT_MAX);
  end

  assign busy      = (state == ST_RUN);
  assign donePulse = doneReg;

  // R2: counter steps by one while the ramp runs
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (count == $past(count) + 1'b1));
  // R2: a new ramp always begins at zero
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (count == '0));
  // R6: completion is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R6: completion follows the end of the busy window
  a_r6_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> donePulse);
endmodule

// File: rtl/wilk_cell.sv
module wilk_cell #(
  parameter int CNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cmpIn,
  input  wilk_pkg::ctlStrobes_t strobes,
  input  logic [CNT_W-1:0]      count,
  output logic [CNT_W-1:0]      code,
  output logic                  ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic syncA, syncB, prevB, fired, riseSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= cmpIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign riseSeen = syncB & ~prevB;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      code  <= '0;
      fired <= 1'b0;
      ovf   <= 1'b0;
    end else if (strobes.captureEn) begin
      if (riseSeen && !fired) begin
        code  <= count;
        fired <= 1'b1;
      end else if (strobes.finalize && !fired) begin
        code  <= CNT_MAX;
        fired <= 1'b1;
        ovf   <= 1'b1;
      end
    end
  end

  // R5: an overflowed cell always carries full scale
  a_r5_ovf_full: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (code == CNT_MAX));
  // R4: once fired, the code holds for the rest of the ramp
  a_r4_hold_code: assert property (@(posedge clk) disable iff (!rstN)
    (fired && strobes.captureEn) |=> $stable(code));
endmodule

// File: rtl/wilk_datapath.sv
module wilk_datapath #(
  parameter int NUM_CELLS = 32,
  parameter int CNT_W     = 12,
  parameter int ADDR_W    = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_CELLS-1:0]  cmpIn,
  input  wilk_pkg::ctlStrobes_t strobes,
  input  logic [CNT_W-1:0]      count,
  input  logic                  busy,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [CNT_W-1:0]      rdData,
  output logic                  rdOvf,
  output logic                  rdValid
);
  logic [CNT_W-1:0]     cellCode [NUM_CELLS];
  logic [NUM_CELLS-1:0] cellOvf;
  logic                 addrOk;

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    wilk_cell #(.CNT_W(CNT_W)) cell_i (
      .clk     (clk),
      .rstN    (rstN),
      .cmpIn   (cmpIn[c]),
      .strobes (strobes),
      .count   (count),
      .code    (cellCode[c]),
      .ovf     (cellOvf[c])
    );
  end

  assign addrOk = ({1'b0, rdAddr} < (ADDR_W+1)'(NUM_CELLS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdOvf   <= 1'b0;
    end else begin
      rdValid <= rdEn && !busy && addrOk;
      if (rdEn && !busy && addrOk) begin
        rdData <= cellCode[rdAddr];
        rdOvf  <= cellOvf[rdAddr];
      end
    end
  end

  // R8: nothing is returned for a request made during a ramp
  a_r8_refuse_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdValid);
  // R7: valid data only answers a request
  a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));
endmodule

// File: rtl/wilk_latch_bank.sv
module wilk_latch_bank #(
  parameter int NUM_CELLS = 32,
  parameter int CNT_W     = 12,
  parameter int ADDR_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [NUM_CELLS-1:0] cmpIn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [CNT_W-1:0]     rdData,
  output logic                 rdOvf,
  output logic                 rdValid,
  output logic                 busy,
  output logic                 donePulse
);
  wilk_pkg::ctlStrobes_t strobes;
  logic [CNT_W-1:0]      count;

  wilk_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .strobes   (strobes),
    .count     (count),
    .busy      (busy),
    .donePulse (donePulse)
  );

  wilk_datapath #(.NUM_CELLS(NUM_CELLS), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmpIn   (cmpIn),
    .strobes (strobes),
    .count   (count),
    .busy    (busy),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .rdOvf   (rdOvf),
    .rdValid (rdValid)
  );
endmodule

// File: tb/wilk_latch_bank_tb_top.sv
module wilk_latch_bank_tb_top;
  localparam int NC   = 32;
  localparam int CW   = 12;
  localparam int AW   = 5;
  localparam int CMAX = 4095;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [NC-1:0] cmpIn = '0;
  logic rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [CW-1:0] rdData;
  logic rdOvf, rdValid, busy, donePulse;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wilk_latch_bank #(.NUM_CELLS(NC), .CNT_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cmpIn(cmpIn),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdOvf(rdOvf),
    .rdValid(rdValid), .busy(busy), .donePulse(donePulse));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference: cmp seen through a 3-deep delay line
  int  mCode[NC];
  bit  mOvf[NC], mFired[NC];
  bit  dl1[NC], dl2[NC], dl3[NC];
  bit  mBusy, mDone, mValid, mOvfR;
  int  mCount, mData;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mValid = 0; mOvfR = 0; mCount = 0; mData = 0;
      for (int c = 0; c < NC; c++) begin
        mCode[c] = 0; mOvf[c] = 0; mFired[c] = 0;
        dl1[c] = 0; dl2[c] = 0; dl3[c] = 0;
      end
    end else begin
      mValid = rdEn && !mBusy && (int'(rdAddr) < NC);
      if (mValid) begin
        mData = mCode[rdAddr];
        mOvfR = mOvf[rdAddr];
      end
      mDone = 0;
      if (mBusy) begin
        for (int c = 0; c < NC; c++)
          if (dl2[c] && !dl3[c] && !mFired[c]) begin
            mCode[c] = mCount; mFired[c] = 1;
          end
        if (mCount == CMAX) begin
          for (int c = 0; c < NC; c++)
            if (!mFired[c]) begin
              mCode[c] = CMAX; mOvf[c] = 1; mFired[c] = 1;
            end
          mBusy = 0; mDone = 1;
        end else mCount++;
      end else if (startIn) begin
        mBusy = 1; mCount = 0;
        for (int c = 0; c < NC; c++) begin
          mCode[c] = 0; mOvf[c] = 0; mFired[c] = 0;
        end
      end
      for (int c = 0; c < NC; c++) begin
        dl3[c] = dl2[c]; dl2[c] = dl1[c]; dl1[c] = cmpIn[c];
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R2 busy vs model", int'(busy), int'(mBusy));
      chk("R6 donePulse vs model", int'(donePulse), int'(mDone));
      chk("R7/R8 rdValid vs model", int'(rdValid), int'(mValid));
      if (rdValid && mValid) begin
        chk("R3 rdData vs model", int'(rdData), mData);
        chk("R5 rdOvf vs model", int'(rdOvf), int'(mOvfR));
      end
    end
  end

  // stimulus plan per cell: high when (j>=r1 && (f<0 || j<f)) || (r2>=0 && j>=r2)
  int r1[NC], f1[NC], r2[NC];

  function automatic logic lvl(int c, int j);
    return ((r1[c] != -999) && j >= r1[c] && (f1[c] < 0 || j < f1[c])) ||
           (r2[c] >= 0 && j >= r2[c]);
  endfunction

  task automatic applyLevels(int j);
    for (int c = 0; c < NC; c++) cmpIn[c] = lvl(c, j);
  endtask

  task automatic readCell(input int a, output int d, output int o, output int v);
    rdEn = 1; rdAddr = AW'(a);
    @(negedge clk);
    rdEn = 0;
    d = int'(rdData); o = int'(rdOvf); v = int'(rdValid);
  endtask

  task automatic runConv(input bit withRead);
    applyLevels(-1);
    repeat (4) @(negedge clk);
    startIn = 1;
    if (withRead) begin rdEn = 1; rdAddr = 0; end
    @(negedge clk);
    startIn = 0; rdEn = 0;
    for (int j = 0; j <= 4100; j++) begin
      applyLevels(j);
      if (j == 500) startIn = 1;
      if (j == 501) startIn = 0;
      if (j == 700) begin rdEn = 1; rdAddr = 3; end
      if (j == 701) begin
        rdEn = 0;
        chk("R8 read refused while busy", int'(rdValid), 0);
      end
      if (j == 4095) begin
        chk("R2 busy in last count cycle", int'(busy), 1);
        chk("R6 no done before terminal", int'(donePulse), 0);
      end
      if (j == 4096) begin
        chk("R6 done after terminal", int'(donePulse), 1);
        chk("R6 busy low with done", int'(busy), 0);
      end
      if (j == 4097) chk("R6 done single cycle", int'(donePulse), 0);
      @(negedge clk);
    end
    cmpIn = '0;
  endtask

  initial begin
    int d, o, v;
    for (int c = 0; c < NC; c++) begin r1[c] = -999; f1[c] = -1; r2[c] = -1; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(donePulse), 0);
    chk("R1 rdValid after reset", int'(rdValid), 0);
    readCell(7, d, o, v);
    chk("R1 reset code", d, 0);
    chk("R1 reset ovf", o, 0);
    chk("R7 idle read valid", v, 1);
    readCell(40 % NC + NC, d, o, v); // address wraps to AW bits; valid read
    chk("R7 second read valid", v, 1);

    // conversion 1: directed patterns
    r1[0] = 10;
    r1[1] = 100; f1[1] = 200; r2[1] = 300;
    r1[2] = -5;  f1[2] = 50;  r2[2] = 60;
    r1[3] = 4093;
    r1[4] = 4094;
    runConv(0);
    readCell(0, d, o, v);
    chk("R3 early edge code", d, 12);
    chk("R7 read valid", v, 1);
    readCell(1, d, o, v);
    chk("R4 second toggle ignored", d, 102);
    readCell(2, d, o, v);
    chk("R4 high-at-start not counted", d, 62);
    readCell(3, d, o, v);
    chk("R5 terminal-cycle edge code", d, CMAX);
    chk("R5 terminal-cycle edge no ovf", o, 0);
    readCell(4, d, o, v);
    chk("R5 late edge code", d, CMAX);
    chk("R5 late edge ovf", o, 1);
    readCell(20, d, o, v);
    chk("R5 silent cell ovf", o, 1);
    for (int c = 5; c < NC; c++) readCell(c, d, o, v);

    // conversion 2: spread edges, read overlapping start
    for (int c = 0; c < NC; c++) begin r1[c] = c * 97 + 5; f1[c] = -1; r2[c] = -1; end
    r1[NC-1] = -999;
    runConv(1);
    readCell(4, d, o, v);
    chk("R9 old ovf cleared by start", o, 0);
    chk("R3 spread edge code", d, 4 * 97 + 7);
    readCell(NC-1, d, o, v);
    chk("R5 silent cell ovf conv2", o, 1);
    for (int c = 0; c < NC; c++) readCell(c, d, o, v);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule